// File: doc/BRIEF.md
# Four-Level Page Table Walker with Upper-Level Walk Cache

This engine resolves a translation that missed in the TLB. It receives a virtual page number from a 48-bit virtual address with 4 KB pages. It walks a four-level page table in memory and returns either the physical frame number or a fault. The result goes to the TLB fill port. The engine issues its table reads one after another through a simple request/response memory port, one read per level. It goes from the top level down to the final table level.

Upper levels of the table change rarely for a given process, so the engine keeps a small walk cache. Each cache entry is tagged by the virtual address bits above the last-level index and holds the base frame of the final-level table. A walk that hits this cache issues a single final-level read instead of four. A flush input empties the cache when the tables are rewritten. The engine runs one walk at a time. It holds `busy` while walking and reports the outcome with a one-cycle done pulse.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `busy`, `memReqValid` and `doneValid` are low.
- R2: Each read address is `base * 4096 + index * 8`. The index for the four levels, in walk order, is VPN bits 35:27, 26:18, 17:9 and 8:0 (VA bits 47:39, 38:30, 29:21, 20:12). The first level's base is `rootPfn`. Every later base is bits 51:12 of the entry read at the level before.
- R3: On a walk-cache miss, the engine issues exactly four reads, top level first. If every entry has bit 0 (present) set, `donePfn` carries bits 51:12 of the final entry and `doneFault` is 0.
- R4: An entry read with bit 0 clear, at any level, ends the walk with `doneFault` = 1 and `donePfn` = 0. No further read is issued for that walk.
- R5: When VPN bits 35:9 match a valid walk-cache entry, the walk issues one read only. That read is the final-level read, and it uses the cached base.
- R6: Only a walk that missed the cache and ends without a fault writes the cache. A faulting walk leaves the cache unchanged.
- R7: The cache holds 4 entries. After a flush, successive fills take slots 0, 1, 2 and 3. The fifth fill replaces the oldest-filled entry.
- R8: A `flush` pulse invalidates every cache entry, so the next walk in any region issues four reads.
- R9: A read request stays asserted with a stable address until `memReqReady` is seen. A response may arrive any number of cycles later.
- R10: A request is taken only while `busy` is low. While `busy` is high, `reqValid` is ignored, and the walk in progress completes with its own result.
- R11: `doneValid` is a single-cycle pulse. It rises the cycle after the response that ends the walk is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk for `reqVpn` (taken when not busy) |
| reqVpn | input | 36 | Virtual page number (VA bits 47:12) |
| rootPfn | input | 40 | Frame number of the top-level table |
| flush | input | 1 | Invalidate all walk-cache entries |
| busy | output | 1 | A walk is in progress |
| memReqValid | output | 1 | Table read request |
| memReqReady | input | 1 | Memory accepts the read request |
| memReqAddr | output | 52 | Physical byte address of the table entry |
| memRspValid | input | 1 | Read data is valid |
| memRspData | input | 64 | Table entry read |
| doneValid | output | 1 | One-cycle completion pulse |
| donePfn | output | 40 | Translated physical frame number |
| doneFault | output | 1 | Walk ended on a not-present entry |

## Verification
A request taken at one clock edge shows up as a memory read on the very next cycle. After each response, the next read, or the done pulse, follows one cycle later. The bench's memory model drives its inputs on falling edges and samples on falling edges. It records the cycle in which it presents each response, and it requires `doneValid` to be high exactly one cycle later and low the cycle after that. The number of reads and each read address are logged per walk. They are compared with addresses computed by walking the bench's own table image, so a cache hit shows up as a single final-level read.

// File: rtl/walk_pkg.sv
package walk_pkg;

  // Strobes from the walk controller to the datapath
  typedef struct packed {
    logic capture;   // latch a new request, choose start level
    logic advance;   // present entry at an upper level: descend
    logic finish;    // walk ends this cycle (result in rsp)
    logic fill;      // walk ends successfully: may write walk cache
  } walkStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walkState_e;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        rspPresent,
  input  logic        atFinal,
  output walkStrobe_t strobe,
  output logic        busy,
  output logic        memReqValid,
  output logic        doneValid
);

  walkState_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (memReqReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (!rspPresent || atFinal) begin
            strobe.finish = 1'b1;
            strobe.fill   = rspPresent;
            stateNext     = ST_IDLE;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = ST_ISSUE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneValid <= 1'b0;
    end else begin
      state     <= stateNext;
      doneValid <= strobe.finish;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);

  // R4: a not-present entry ends the walk with no further read
  assert_no_read_after_fault_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && memRspValid && !rspPresent) |=> (!memReqValid && !busy && doneValid));

  // R9: an unaccepted request stays up
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  // R11: completion is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R10: a walk starts only from a request
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

endmodule

// File: rtl/walk_path.sv
module walk_path
  import walk_pkg::*;
#(
  parameter int VPN_W   = 36,
  parameter int PFN_W   = 40,
  parameter int DATA_W  = 64,
  parameter int LEVELS  = 4,
  parameter int IDX_W   = 9,
  parameter int WC_N    = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  walkStrobe_t                    strobe,
  input  logic                           flush,
  input  logic [VPN_W-1:0]               reqVpn,
  input  logic [PFN_W-1:0]               rootPfn,
  input  logic [DATA_W-1:0]              rspData,
  output logic [PFN_W+IDX_W+2:0]         memReqAddr,
  output logic                           rspPresent,
  output logic                           atFinal,
  output logic [PFN_W-1:0]               donePfn,
  output logic                           doneFault
);

  localparam int PAGE_SH  = 12;
  localparam int ENTRY_SH = 3;
  localparam int PA_W     = PFN_W + PAGE_SH;
  localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int TAG_W    = VPN_W - IDX_W;
  localparam int WC_W     = (WC_N > 1) ? $clog2(WC_N) : 1;
  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(LEVELS - 1);
  localparam logic [WC_W-1:0]  WC_LAST  = WC_W'(WC_N - 1);

  // ---------------- walk registers ----------------
  logic [VPN_W-1:0] walkVpn;
  logic [PFN_W-1:0] curBase;
  logic [PFN_W-1:0] finalBase;
  logic [LVL_W-1:0] level;
  logic             startedHit;

  // ---------------- walk cache ----------------
  logic [WC_N-1:0]  wcValid;
  logic [TAG_W-1:0] wcTag  [WC_N];
  logic [PFN_W-1:0] wcBase [WC_N];
  logic [WC_W-1:0]  rrPtr;
  logic [WC_N-1:0]  hitVec;
  logic [PFN_W-1:0] hitBase;
  logic             lookupHit;
  logic [TAG_W-1:0] reqTag;

  assign reqTag = reqVpn[VPN_W-1:IDX_W];

  genvar gi;
  generate
    for (gi = 0; gi < WC_N; gi++) begin : g_cmp
      assign hitVec[gi] = wcValid[gi] && (wcTag[gi] == reqTag);
    end
  endgenerate

  always_comb begin
    hitBase = '0;
    for (int i = 0; i < WC_N; i++) begin
      if (hitVec[i]) hitBase = hitBase | wcBase[i];
    end
  end
  assign lookupHit = |hitVec;

  // ---------------- per-level index fields ----------------
  logic [IDX_W-1:0] lvlIdx [LEVELS];
  generate
    for (gi = 0; gi < LEVELS; gi++) begin : g_idx
      assign lvlIdx[gi] = walkVpn[IDX_W*(LEVELS-1-gi) +: IDX_W];
    end
  endgenerate

  logic [PFN_W-1:0] rspFrame;
  logic             unusedRspBits;
  assign rspFrame      = rspData[PA_W-1:PAGE_SH];
  assign rspPresent    = rspData[0];
  assign unusedRspBits = ^{rspData[DATA_W-1:PA_W], rspData[PAGE_SH-1:1]};
  assign atFinal       = (level == LVL_LAST);
  assign memReqAddr    = {curBase, lvlIdx[level], {ENTRY_SH{1'b0}}};

  // ---------------- walk state ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkVpn    <= '0;
      curBase    <= '0;
      finalBase  <= '0;
      level      <= '0;
      startedHit <= 1'b0;
      donePfn    <= '0;
      doneFault  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        walkVpn    <= reqVpn;
        startedHit <= lookupHit;
        if (lookupHit) begin
          curBase <= hitBase;
          level   <= LVL_LAST;
        end else begin
          curBase <= rootPfn;
          level   <= '0;
        end
      end
      if (strobe.advance) begin
        curBase <= rspFrame;
        level   <= level + 1'b1;
        if (level == LVL_W'(LEVELS - 2)) finalBase <= rspFrame;
      end
      if (strobe.finish) begin
        donePfn   <= rspPresent ? rspFrame : '0;
        doneFault <= !rspPresent;
      end
    end
  end

  // ---------------- walk cache update ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wcValid <= '0;
      rrPtr   <= '0;
      for (int i = 0; i < WC_N; i++) begin
        wcTag[i]  <= '0;
        wcBase[i] <= '0;
      end
    end else if (flush) begin
      wcValid <= '0;
      rrPtr   <= '0;
    end else if (strobe.fill && !startedHit) begin
      wcValid[rrPtr] <= 1'b1;
      wcTag[rrPtr]   <= walkVpn[VPN_W-1:IDX_W];
      wcBase[rrPtr]  <= finalBase;
      rrPtr          <= (rrPtr == WC_LAST) ? '0 : rrPtr + 1'b1;
    end
  end

  // R5: at most one entry matches a lookup
  assert_hit_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R8: flush empties the cache
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (wcValid == '0));

  // R6: a faulting walk leaves the cache untouched
  assert_fault_no_fill_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !strobe.fill && !flush) |=> $stable(wcValid));

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import walk_pkg::*;
#(
  parameter int VPN_W  = 36,
  parameter int PFN_W  = 40,
  parameter int DATA_W = 64,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int WC_N   = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [VPN_W-1:0]       reqVpn,
  input  logic [PFN_W-1:0]       rootPfn,
  input  logic                   flush,
  output logic                   busy,
  output logic                   memReqValid,
  input  logic                   memReqReady,
  output logic [PFN_W+11:0]      memReqAddr,
  input  logic                   memRspValid,
  input  logic [DATA_W-1:0]      memRspData,
  output logic                   doneValid,
  output logic [PFN_W-1:0]       donePfn,
  output logic                   doneFault
);

  walkStrobe_t strobe;
  logic        rspPresent;
  logic        atFinal;

  walk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .rspPresent (rspPresent),
    .atFinal    (atFinal),
    .strobe     (strobe),
    .busy       (busy),
    .memReqValid(memReqValid),
    .doneValid  (doneValid)
  );

  walk_path #(
    .VPN_W (VPN_W),
    .PFN_W (PFN_W),
    .DATA_W(DATA_W),
    .LEVELS(LEVELS),
    .IDX_W (IDX_W),
    .WC_N  (WC_N)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .flush     (flush),
    .reqVpn    (reqVpn),
    .rootPfn   (rootPfn),
    .rspData   (memRspData),
    .memReqAddr(memReqAddr),
    .rspPresent(rspPresent),
    .atFinal   (atFinal),
    .donePfn   (donePfn),
    .doneFault (doneFault)
  );

  // R9: address does not move while the request waits
  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));

endmodule

// File: tb/sim_xlate_walker.sv
module sim_xlate_walker;

  localparam int CLK_PERIOD = 10;
  localparam logic [39:0] ROOT = 40'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [35:0] reqVpn = '0;
  logic [39:0] rootPfn = ROOT;
  logic        flush = 1'b0;
  logic        busy, memReqValid, doneValid, doneFault;
  logic        memReqReady = 1'b0;
  logic [51:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic [39:0] donePfn;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_walker u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVpn(reqVpn), .rootPfn(rootPfn),
    .flush(flush), .busy(busy), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .donePfn(donePfn), .doneFault(doneFault)
  );

  int checks = 0, fails = 0;
  int cycleCnt = 0;
  int rspStamp = 0;
  int readyLag = 0, rspLag = 0;
  int rdCnt = 0;
  logic [51:0] rdAddr [8];
  logic [63:0] mem [logic [51:0]];
  logic [39:0] nextFrame = 40'h200;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] ix(input logic [35:0] vpn, input int lvl);
    return vpn[9*(3-lvl) +: 9];
  endfunction

  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] pte(input logic [39:0] pfn);
    return {12'h0, pfn, 11'h0, 1'b1};
  endfunction

  function automatic logic [51:0] lvlAddr(input logic [35:0] vpn, input int lvl);
    logic [39:0] b = ROOT;
    for (int l = 0; l < lvl; l++) b = rd({b, ix(vpn, l), 3'b000})[51:12];
    return {b, ix(vpn, lvl), 3'b000};
  endfunction

  task automatic mapPage(input logic [35:0] vpn, input logic [39:0] pfn);
    logic [39:0] b = ROOT;
    for (int l = 0; l < 3; l++) begin
      logic [51:0] a = {b, ix(vpn, l), 3'b000};
      if (!mem.exists(a)) begin
        mem[a] = pte(nextFrame);
        nextFrame = nextFrame + 1;
      end
      b = mem[a][51:12];
    end
    mem[{b, ix(vpn, 3), 3'b000}] = pte(pfn);
  endtask

  // Memory model: accepts after readyLag cycles, answers after rspLag more
  task automatic responder();
    forever begin
      @(negedge clk);
      if (memReqValid && !memReqReady) begin
        repeat (readyLag) @(negedge clk);
        memReqReady = 1'b1;
        if (rdCnt < 8) rdAddr[rdCnt] = memReqAddr;
        rdCnt++;
        @(negedge clk);
        memReqReady = 1'b0;
        repeat (rspLag) @(negedge clk);
        memRspValid = 1'b1;
        memRspData  = rd(rdAddr[(rdCnt < 8) ? rdCnt-1 : 7]);
        rspStamp    = cycleCnt;
        @(negedge clk);
        memRspValid = 1'b0;
        memRspData  = '0;
      end
    end
  endtask

  task automatic startWalk(input logic [35:0] vpn);
    rdCnt = 0;
    @(negedge clk);
    reqVpn   = vpn;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    int t = 0;
    while (!doneValid && t < 500) begin
      @(negedge clk);
      t++;
    end
    seen = doneValid;
  endtask

  task automatic runWalk(input logic [35:0] vpn, input bit expFault, input logic [39:0] expPfn,
                         input int expReads, input int firstLvl, input string req);
    bit seen;
    startWalk(vpn);
    waitDone(seen);
    check(seen, {req, " R11 done seen"}, 64'(seen), 64'd1);
    check(cycleCnt == rspStamp + 1, {req, " R11 done one cycle after response"}, 64'(cycleCnt), 64'(rspStamp + 1));
    check(doneFault == expFault, {req, " R4 fault flag"}, 64'(doneFault), 64'(expFault));
    check(donePfn == (expFault ? 40'h0 : expPfn), {req, " R3 pfn"}, 64'(donePfn), 64'(expFault ? 40'h0 : expPfn));
    check(rdCnt == expReads, {req, " R5 read count"}, 64'(rdCnt), 64'(expReads));
    for (int k = 0; k < rdCnt && k < expReads && k < 8; k++)
      check(rdAddr[k] == lvlAddr(vpn, firstLvl + k), {req, " R2 read address"}, 64'(rdAddr[k]), 64'(lvlAddr(vpn, firstLvl + k)));
    @(negedge clk);
    check(!doneValid, {req, " R11 single-cycle pulse"}, 64'(doneValid), 64'd0);
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // Base region used by most tests
  localparam logic [35:0] VA_A  = 36'h1_2345_6000 >> 0;
  localparam logic [35:0] VPN_A = 36'h0_1234_5;

  task automatic testReset();
    check(!busy, "R1 busy after reset", 64'(busy), 0);
    check(!memReqValid, "R1 memReqValid after reset", 64'(memReqValid), 0);
    check(!doneValid, "R1 doneValid after reset", 64'(doneValid), 0);
  endtask

  task automatic testMissWalk();   // R3, R2
    runWalk(VPN_A, 1'b0, 40'hABCDE, 4, 0, "miss walk R3");
  endtask

  task automatic testCacheHit();   // R5 with slow memory (R9)
    readyLag = 2; rspLag = 3;
    runWalk(VPN_A + 36'd1, 1'b0, 40'h05555, 1, 3, "cache hit R5 R9");
    readyLag = 0; rspLag = 0;
  endtask

  task automatic testTopFault();   // R4
    runWalk(36'hF_0000_000, 1'b1, 40'h0, 1, 0, "top-level fault R4");
  endtask

  task automatic testFinalFaultNoFill();  // R6
    logic [35:0] p = 36'h0_2000_040;
    logic [35:0] q = p + 36'd3;
    mapPage(p, 40'h7_7777);
    runWalk(q, 1'b1, 40'h0, 4, 0, "final fault R6 first");
    runWalk(q, 1'b1, 40'h0, 4, 0, "final fault R6 no fill");
    runWalk(p, 1'b0, 40'h7_7777, 4, 0, "fill after success R6");
    runWalk(q, 1'b1, 40'h0, 1, 3, "hit then final fault R6");
  endtask

  task automatic testFlush();      // R8
    doFlush();
    runWalk(VPN_A, 1'b0, 40'hABCDE, 4, 0, "after flush R8");
  endtask

  task automatic testReplace();    // R7
    doFlush();
    for (int r = 1; r <= 5; r++)
      runWalk(36'h0_3000_000 + 36'(r << 9), 1'b0, 40'(36'h100 + r), 4, 0, "replace fill R7");
    runWalk(36'h0_3000_000 + 36'(2 << 9), 1'b0, 40'h102, 1, 3, "second region kept R7");
    runWalk(36'h0_3000_000 + 36'(1 << 9), 1'b0, 40'h101, 4, 0, "oldest evicted R7");
  endtask

  task automatic testBusyIgnore(); // R10
    bit seen;
    startWalk(VPN_A);
    check(busy, "R10 busy during walk", 64'(busy), 64'd1);
    reqVpn   = 36'h0_3000_000 + 36'(2 << 9);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(seen);
    check(seen && donePfn == 40'hABCDE, "R10 busy walk keeps own result", 64'(donePfn), 64'hABCDE);
    repeat (3) @(negedge clk);
    check(!busy && !memReqValid, "R10 ignored request started nothing", 64'({busy, memReqValid}), 64'd0);
  endtask

  initial begin
    mapPage(VPN_A, 40'hABCDE);
    mapPage(VPN_A + 36'd1, 40'h05555);
    for (int r = 1; r <= 5; r++) mapPage(36'h0_3000_000 + 36'(r << 9), 40'(36'h100 + r));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    fork responder(); join_none
    testReset();
    testMissWalk();
    testCacheHit();
    testTopFault();
    testFinalFaultNoFill();
    testFlush();
    testReplace();
    testBusyIgnore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule